// File: doc/BRIEF.md
# Lockable Configuration Store

This block holds the nonvolatile configuration of a small programmable logic device as its programming port sees it. It keeps a fuse array of `NWORDS` words of `DW` bits, a 64-bit user signature and a one-way security flag. The whole array is driven in parallel onto `fabric_cfg` for the logic fabric. Commands arrive one per cycle on the command port. Each command is answered exactly one cycle later with a `done` pulse, any read data, and a `blocked` flag when the security flag refuses it.

Once the lock command has run, the array can no longer be read back, programmed or verified, and the signature cannot be rewritten. Signature reads and register-preload permission stay available. Only a full erase returns the array and signature to all ones and clears the lock. Programming a word replaces its old contents, so no erase command is needed before it.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset, `done`, `blocked`, `verify_ok` and `preload_ok` are 0, `locked` is 0, and every bit of `fabric_cfg` is 1.
- R2: A command sampled with `cmd_valid`=1 produces `done`=1 in the following cycle. `done` is 0 in every cycle that does not follow an accepted command.
- R3: Program (code 2) replaces the whole word at `cmd_addr` with `cmd_wdata`, whatever it held before. Word k appears on `fabric_cfg[k*DW +: DW]`.
- R4: Read (code 3) returns the stored word at `cmd_addr` on `rdata` while unlocked.
- R5: Verify (code 4) sets `verify_ok`=1 only when unlocked and the stored word equals `cmd_wdata`; otherwise `verify_ok` is 0.
- R6: Lock (code 7) raises `locked` in the cycle after it is sampled, and a command issued in that next cycle already sees the lock.
- R7: While locked, codes 2, 3, 4 and 5 answer with `blocked`=1, `rdata`=0 and `verify_ok`=0, and they leave the array and signature unchanged.
- R8: Erase (code 1) is never blocked. It sets every array bit and every signature bit to 1 and clears `locked`.
- R9: Signature read (code 6) is never blocked. It returns signature bits `[s*DW +: DW]`, where s is the low `$clog2(64/DW)` bits of `cmd_addr`.
- R10: Signature program (code 5) replaces signature chunk s (same selection as R9) with `cmd_wdata` while unlocked.
- R11: Preload permit (code 0) is never blocked and answers with `preload_ok`=1, locked or not.
- R12: `locked` falls only as a result of an erase; after lock it holds through any other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_addr | input | AW | Array word index or signature chunk index |
| cmd_wdata | input | DW | Program or compare data |
| done | output | 1 | One-cycle completion pulse |
| blocked | output | 1 | Command refused by the security flag |
| rdata | output | DW | Read or signature data, 0 otherwise |
| verify_ok | output | 1 | Compare matched |
| preload_ok | output | 1 | Preload permission granted |
| locked | output | 1 | Security flag |
| fabric_cfg | output | NWORDS*DW | Parallel view of the array |

## Verification
The assertions assume reset is held for at least one edge before any command. They also assume `NWORDS` is a power of two and at least `64/DW`, so every `cmd_addr` value names a real word. Every 3-bit code is legal, and commands may follow one another with no gap. The stimulus changes inputs only on the falling edge. It runs lock and read in consecutive cycles, sends each guarded code while locked, and ends with an erase, so every transition of the security flag is reached.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [2:0] {
    OP_PRELOAD = 3'd0,
    OP_ERASE   = 3'd1,
    OP_PROG    = 3'd2,
    OP_READ    = 3'd3,
    OP_VERIFY  = 3'd4,
    OP_SIGPROG = 3'd5,
    OP_SIGREAD = 3'd6,
    OP_LOCK    = 3'd7
  } cfg_op_e;

  // granted strobes, one per command class
  typedef struct packed {
    logic preload;
    logic erase;
    logic prog;
    logic read;
    logic verify;
    logic sig_prog;
    logic sig_read;
    logic lock;
  } cfg_req_t;

  // commands that the security flag can refuse
  function automatic logic op_guarded(cfg_op_e op);
    return (op == OP_PROG) || (op == OP_READ) ||
           (op == OP_VERIFY) || (op == OP_SIGPROG);
  endfunction

  // signature chunk selection from an address
  function automatic int unsigned sig_index(int unsigned addr, int unsigned chunks);
    return addr % chunks;
  endfunction

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_lock_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic                sec,
  output cfg_req_t            req,
  output logic                refuse
);
  cfg_op_e op;
  logic    guarded;

  always_comb begin
    op      = cfg_op_e'(cmd_op);
    guarded = op_guarded(op);
    refuse  = cmd_valid && guarded && sec;
    req     = '0;
    if (cmd_valid && !refuse) begin
      unique case (op)
        OP_PRELOAD: req.preload  = 1'b1;
        OP_ERASE:   req.erase    = 1'b1;
        OP_PROG:    req.prog     = 1'b1;
        OP_READ:    req.read     = 1'b1;
        OP_VERIFY:  req.verify   = 1'b1;
        OP_SIGPROG: req.sig_prog = 1'b1;
        OP_SIGREAD: req.sig_read = 1'b1;
        OP_LOCK:    req.lock     = 1'b1;
        default:    req          = '0;
      endcase
    end
  end

  // R7: a granted guarded command never coexists with the flag set
  assert_guard_respected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec |-> !(req.prog || req.read || req.verify || req.sig_prog));
  // R2: at most one class granted
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));

endmodule

// File: rtl/cfg_sec_latch.sv
module cfg_sec_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic sec_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sec_o <= 1'b0;
    else if (clr_i)  sec_o <= 1'b0;
    else if (set_i)  sec_o <= 1'b1;
  end

  // R12: the flag only drops after an erase
  assert_clear_by_erase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_o) |-> $past(clr_i));
  // R6: the flag only rises after a lock
  assert_set_by_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_o) |-> $past(set_i));

endmodule

// File: rtl/cfg_fuse_store.sv
module cfg_fuse_store #(
  parameter int NWORDS   = 8,
  parameter int DW       = 16,
  parameter int SIG_BITS = 64,
  localparam int AW        = $clog2(NWORDS),
  localparam int SIG_WORDS = SIG_BITS / DW,
  localparam int SAW       = (SIG_WORDS > 1) ? $clog2(SIG_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 erase,
  input  logic                 prog,
  input  logic                 sig_prog,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [NWORDS*DW-1:0] fabric,
  output logic [DW-1:0]        rd_word,
  output logic [DW-1:0]        sig_chunk
);
  logic [DW-1:0] mem [NWORDS];
  logic [DW-1:0] sig [SIG_WORDS];
  logic [SAW-1:0] sel;

  assign sel = SAW'(cfg_lock_pkg::sig_index(32'(addr), SIG_WORDS));

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = prog && (addr == AW'(w));
    always_ff @(posedge clk) begin
      if (!rst_n || erase) mem[w] <= '1;
      else if (hit)        mem[w] <= wdata;
    end
    assign fabric[w*DW +: DW] = mem[w];
  end

  for (genvar s = 0; s < SIG_WORDS; s++) begin : g_sig
    logic hit;
    assign hit = sig_prog && (sel == SAW'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || erase) sig[s] <= '1;
      else if (hit)        sig[s] <= wdata;
    end
  end

  assign rd_word   = mem[addr];
  assign sig_chunk = sig[sel];

  // R7: array content moves only on a granted program or erase
  assert_array_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !erase && !prog |=> $stable(fabric));
  // R8: erase leaves every bit at one
  assert_erase_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (&fabric));

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
  import cfg_lock_pkg::*;
#(
  parameter int NWORDS   = 8,
  parameter int DW       = 16,
  parameter int SIG_BITS = 64,
  localparam int AW      = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [AW-1:0]        cmd_addr,
  input  logic [DW-1:0]        cmd_wdata,
  output logic                 done,
  output logic                 blocked,
  output logic [DW-1:0]        rdata,
  output logic                 verify_ok,
  output logic                 preload_ok,
  output logic                 locked,
  output logic [NWORDS*DW-1:0] fabric_cfg
);
  cfg_req_t      req;
  logic          refuse;
  logic          sec;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] sig_chunk;

  cfg_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .sec(sec), .req(req), .refuse(refuse)
  );

  cfg_sec_latch u_sec (
    .clk(clk), .rst_n(rst_n), .set_i(req.lock), .clr_i(req.erase), .sec_o(sec)
  );

  cfg_fuse_store #(.NWORDS(NWORDS), .DW(DW), .SIG_BITS(SIG_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(req.erase), .prog(req.prog),
    .sig_prog(req.sig_prog), .addr(cmd_addr), .wdata(cmd_wdata),
    .fabric(fabric_cfg), .rd_word(rd_word), .sig_chunk(sig_chunk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      blocked    <= 1'b0;
      rdata      <= '0;
      verify_ok  <= 1'b0;
      preload_ok <= 1'b0;
    end else begin
      done       <= cmd_valid;
      blocked    <= refuse;
      rdata      <= req.read     ? rd_word   :
                    req.sig_read ? sig_chunk : '0;
      verify_ok  <= req.verify && (rd_word == cmd_wdata);
      preload_ok <= req.preload;
    end
  end

  assign locked = sec;

  // R2: every command is answered in the next cycle
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  // R7: a refusal carries no data
  assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (done && rdata == '0 && !verify_ok));
  // R9: signature read is never refused
  assert_sig_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> !blocked);
  // R11: preload is never refused
  assert_preload_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> (preload_ok && !blocked));

endmodule

// File: tb/sim_cfg_lock_store.sv
module sim_cfg_lock_store;
  localparam int NW = 8;
  localparam int DW = 16;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic done, blocked, verify_ok, preload_ok, locked;
  logic [DW-1:0] rdata;
  logic [NW*DW-1:0] fabric_cfg;

  always #5 clk = ~clk;

  cfg_lock_store u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .blocked(blocked),
    .rdata(rdata), .verify_ok(verify_ok), .preload_ok(preload_ok),
    .locked(locked), .fabric_cfg(fabric_cfg)
  );

  typedef struct {
    logic          blk;
    logic [DW-1:0] rd;
    logic          vok;
    logic          pre;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic [DW-1:0] mmem [NW];
  logic [DW-1:0] msig [SC];
  logic msec;

  task automatic chk(string tag, logic [NW*DW-1:0] act, logic [NW*DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*DW-1:0] model_fabric();
    logic [NW*DW-1:0] f;
    for (int i = 0; i < NW; i++) f[i*DW +: DW] = mmem[i];
    return f;
  endfunction

  task automatic model_erase();
    for (int i = 0; i < NW; i++) mmem[i] = '1;
    for (int i = 0; i < SC; i++) msig[i] = '1;
    msec = 1'b0;
  endtask

  // driver: computes expectations, pushes them, drives one command cycle
  task automatic issue(logic [2:0] op, int addr, logic [DW-1:0] wd, string tag);
    exp_t e;
    logic g;
    g = (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd5);
    e.blk = g && msec;
    e.rd  = '0;
    if (!e.blk && op == 3'd3) e.rd = mmem[addr];
    if (op == 3'd6)           e.rd = msig[addr % SC];
    e.vok = (op == 3'd4) && !e.blk && (mmem[addr] == wd);
    e.pre = (op == 3'd0);
    e.tag = tag;
    case (op)
      3'd1: model_erase();
      3'd2: if (!e.blk) mmem[addr] = wd;
      3'd5: if (!e.blk) msig[addr % SC] = wd;
      3'd7: msec = 1'b1;
      default: ;
    endcase
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = 3'(addr);
    cmd_wdata = wd;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares as results appear
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rst_n && done) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 done without command act=1 exp=0");
      end else begin
        e = q.pop_front();
        chk({e.tag, " blocked"}, 128'(blocked), 128'(e.blk));
        chk({e.tag, " rdata"}, 128'(rdata), 128'(e.rd));
        chk({e.tag, " verify_ok"}, 128'(verify_ok), 128'(e.vok));
        chk({e.tag, " preload_ok"}, 128'(preload_ok), 128'(e.pre));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_erase();
    repeat (3) @(negedge clk);
    chk("R1 done", 128'(done), 128'(0));
    chk("R1 locked", 128'(locked), 128'(0));
    chk("R1 preload_ok", 128'(preload_ok), 128'(0));
    chk("R1 fabric", fabric_cfg, '1);
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'd2, 2, 16'hA5A5, "R3 program");
    issue(3'd2, 2, 16'h0F0F, "R3 overwrite");
    issue(3'd2, 5, 16'h1234, "R3 program2");
    issue(3'd3, 2, '0, "R4 read2");
    issue(3'd3, 5, '0, "R4 read5");
    issue(3'd3, 0, '0, "R4 read blank");
    issue(3'd4, 2, 16'h0F0F, "R5 verify match");
    issue(3'd4, 2, 16'h0000, "R5 verify miss");
    issue(3'd5, 1, 16'hBEEF, "R10 sig prog1");
    issue(3'd5, 7, 16'hCAFE, "R10 sig prog3 via high addr");
    issue(3'd6, 1, '0, "R9 sig read1");
    issue(3'd6, 3, '0, "R9 sig read3");
    issue(3'd6, 0, '0, "R9 sig read blank");
    issue(3'd0, 0, '0, "R11 preload open");
    idle(1);
    chk("R3 fabric", fabric_cfg, model_fabric());
    chk("R2 idle no done", 128'(done), 128'(0));

    issue(3'd7, 0, '0, "R6 lock");
    issue(3'd3, 2, '0, "R6 R7 read right after lock");
    @(posedge clk); #1;
    chk("R6 locked", 128'(locked), 128'(1));
    issue(3'd2, 2, 16'h0000, "R7 program refused");
    issue(3'd4, 2, 16'h0F0F, "R7 verify refused");
    issue(3'd5, 1, 16'h0000, "R7 sig prog refused");
    issue(3'd6, 1, '0, "R9 sig read while locked");
    issue(3'd0, 0, '0, "R11 preload while locked");
    issue(3'd7, 0, '0, "R12 lock again");
    idle(1);
    chk("R7 fabric unchanged", fabric_cfg, model_fabric());
    chk("R12 still locked", 128'(locked), 128'(1));

    issue(3'd1, 0, '0, "R8 erase");
    idle(1);
    chk("R8 unlocked", 128'(locked), 128'(0));
    chk("R8 fabric ones", fabric_cfg, '1);
    issue(3'd6, 1, '0, "R8 sig erased");
    issue(3'd3, 5, '0, "R8 word erased");
    issue(3'd2, 6, 16'h5A5A, "R3 program after erase");
    issue(3'd3, 6, '0, "R4 readback after erase");
    idle(2);
    chk("R3 fabric final", fabric_cfg, model_fabric());
    chk("R2 all answered", 128'(q.size()), 128'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule